// File: doc/BRIEF.md
# Radix-2 Montgomery Modular Multiplier

This block is a bit-serial modular multiplier. For an odd modulus N it returns A·B·2^-W mod N, where W is the operand width, a parameter that defaults to 64. A pulse on `start` captures the three operands. The block then forms two even multiples of B and walks through A one bit per clock, starting with the least significant bit. A final correction step brings the sum into the range of the modulus. A one-cycle `done` pulse announces the result.

Each iteration looks at two bits: the low bit of the running sum and the current bit of A. These two bits select one of four addends: zero, 2B, N, or 2B+N. The chosen addend always makes the sum even, so the halving that follows is exact. Because the loop works with 2B instead of B, it needs one more pass than the width, W+1 in total. In that extra pass the multiplier bit is zero.

Callers use the block as the inner step of a modular exponentiation. It expects operands already in Montgomery form and B < N.

Top module: `mont_mul`

## Requirements
- R1: With N odd, B < N and any A < 2^W, the `result` that accompanies `done` equals A·B·2^-W mod N. This means the unique r < N with r·2^W ≡ A·B (mod N).
- R2: Every delivered `result` is strictly less than the N captured at the accepted start. The single conditional subtraction of N is enough for this.
- R3: The running sum is held in W+2 bits and never reaches 3·N during the iterations, so no carry out of the sum register is lost.
- R4: `done` rises on the clock edge that comes W+3 edges after the edge that accepts `start`. That edge is the (W+4)-th edge, counting the accepting edge as the first. The span covers one capture edge, one precompute edge, W+1 iteration edges and one correction edge.
- R5: `done` stays high for exactly one clock cycle per accepted start.
- R6: `result` changes only on the edge that raises `done`. Between runs it holds its value regardless of the operand inputs.
- R7: A `start` pulse that arrives while a computation is in progress is ignored. Changes to `opA`, `opB` or `modN` after the accepting edge have no effect on the current result or on its timing.
- R8: While `rst` is high (synchronous, active high), `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; accepted only when idle |
| opA | input | W | Multiplier, consumed least significant bit first |
| opB | input | W | Multiplicand, must be below modN |
| modN | input | W | Odd modulus |
| result | output | W | A·B·2^-W mod N, valid from the `done` pulse onward |
| done | output | 1 | One-cycle completion strobe |

## Verification
An 8-bit instance is swept over every odd modulus from 1 to 255. For each modulus the bench crosses six values of B with eight values of A. The B values include 0, 1 and N-1. The A values include all-zeros, all-ones, the top bit alone and alternating bit patterns. Together these separate the four addend choices, the role of the extra iteration, and the cases that do or do not need the final subtraction.

A 64-bit instance is run with near-maximal operands, such as an all-ones modulus, to expose any truncation of the widened sum. Dedicated runs disturb the operand inputs and pulse `start` in the middle of a computation, and they hold the inputs altered after completion. These runs show that the operands are captured at the accepting edge and that the output is held between runs.

// File: rtl/mont_pkg.sv
package mont_pkg;
  // Strobes from the sequencer to the datapath, one per phase.
  typedef struct packed {
    logic load;  // capture operands
    logic prep;  // form 2B and 2B+N, clear the sum
    logic step;  // one add-and-halve iteration
    logic fix;   // final range correction
  } montCtrl_t;
endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int W = 64
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output montCtrl_t ctl,
  output logic      done
);
  localparam int CW = $clog2(W + 1) + 1;
  localparam logic [CW-1:0] LAST = CW'(W);

  typedef enum logic [1:0] {IDLE, PREP, ITER, FIX} phase_t;

  phase_t        phase, phaseNext;
  logic [CW-1:0] iterCnt;

  always_comb begin
    ctl       = '0;
    phaseNext = phase;
    unique case (phase)
      IDLE: if (start) begin
        ctl.load  = 1'b1;
        phaseNext = PREP;
      end
      PREP: begin
        ctl.prep  = 1'b1;
        phaseNext = ITER;
      end
      ITER: begin
        ctl.step = 1'b1;
        if (iterCnt == LAST) phaseNext = FIX;
      end
      FIX: begin
        ctl.fix   = 1'b1;
        phaseNext = IDLE;
      end
      default: phaseNext = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= ctl.fix;
      if (ctl.prep)      iterCnt <= '0;
      else if (ctl.step) iterCnt <= iterCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mont_dpath.sv
module mont_dpath
  import mont_pkg::*;
#(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  montCtrl_t      ctl,
  input  logic [W-1:0]   aIn,
  input  logic [W-1:0]   bIn,
  input  logic [W-1:0]   nIn,
  output logic [W-1:0]   result
);
  localparam int SW = W + 2;  // accumulator width
  localparam int AW = W + 3;  // sum width before halving

  logic [W:0]    aSh;   // multiplier, shifted right each step; top bit 0
  logic [W-1:0]  bReg;
  logic [W-1:0]  nReg;
  logic [W:0]    xReg;  // 2B
  logic [SW-1:0] yReg;  // 2B + N
  logic [SW-1:0] sAcc;

  logic [SW-1:0] addend;
  logic [AW-1:0] sum;
  logic [SW:0]   diff;

  always_comb begin
    unique case ({sAcc[0], aSh[0]})
      2'b00:   addend = '0;
      2'b01:   addend = SW'(xReg);
      2'b10:   addend = SW'(nReg);
      default: addend = yReg;
    endcase
    sum  = AW'(sAcc) + AW'(addend);
    diff = {1'b0, sAcc} - (SW+1)'(nReg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aSh    <= '0;
      bReg   <= '0;
      nReg   <= '0;
      xReg   <= '0;
      yReg   <= '0;
      sAcc   <= '0;
      result <= '0;
    end else begin
      if (ctl.load) begin
        aSh  <= {1'b0, aIn};
        bReg <= bIn;
        nReg <= nIn;
      end
      if (ctl.prep) begin
        xReg <= {bReg, 1'b0};
        yReg <= SW'({bReg, 1'b0}) + SW'(nReg);
        sAcc <= '0;
      end
      if (ctl.step) begin
        sAcc <= sum[AW-1:1];
        aSh  <= aSh >> 1;
      end
      if (ctl.fix) begin
        result <= diff[SW] ? sAcc[W-1:0] : diff[W-1:0];
      end
    end
  end
endmodule

// File: rtl/mont_mul.sv
module mont_mul
  import mont_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] modN,
  output logic [W-1:0] result,
  output logic         done
);
  montCtrl_t ctl;

  mont_ctrl #(.W(W)) uCtrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .ctl  (ctl),
    .done (done)
  );

  mont_dpath #(.W(W)) uDp (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .aIn   (opA),
    .bIn   (opB),
    .nIn   (modN),
    .result(result)
  );
endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] nLat,
  input logic [W+1:0] sAcc,
  input logic         step
);
  logic [W+2:0] nTriple;
  assign nTriple = (W+3)'(nLat) + (W+3)'({nLat, 1'b0});

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  assert_result_range_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < nLat));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    step |-> ((W+3)'(sAcc) < nTriple));
endmodule

bind mont_mul mont_mul_chk #(.W(W)) uChk (
  .clk   (clk),
  .rst   (rst),
  .done  (done),
  .result(result),
  .nLat  (uDp.nReg),
  .sAcc  (uDp.sAcc),
  .step  (ctl.step)
);

// File: tb/tb_mont_mul.sv
`timescale 1ns/1ps
module tb_mont_mul;
  localparam int WS = 8;
  localparam int WL = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          sStart = 1'b0;
  logic [WS-1:0] sA = '0, sB = '0, sN = '0;
  logic [WS-1:0] sRes;
  logic          sDone;

  logic          lStart = 1'b0;
  logic [WL-1:0] lA = '0, lB = '0, lN = '0;
  logic [WL-1:0] lRes;
  logic          lDone;

  int vectors = 0;
  int miscompares = 0;

  mont_mul #(.W(WS)) dut (
    .clk(clk), .rst(rst), .start(sStart), .opA(sA), .opB(sB), .modN(sN),
    .result(sRes), .done(sDone)
  );

  mont_mul #(.W(WL)) dutWide (
    .clk(clk), .rst(rst), .start(lStart), .opA(lA), .opB(lB), .modN(lN),
    .result(lRes), .done(lDone)
  );

  // r with r*2^w == a*b (mod n): multiply, then halve w times modulo n.
  function automatic logic [127:0] refMont(logic [127:0] a, logic [127:0] b,
                                           logic [127:0] n, int w);
    logic [127:0] x;
    x = (a * b) % n;
    for (int i = 0; i < w; i++) x = x[0] ? ((x + n) >> 1) : (x >> 1);
    return x;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One small run; disturb drives other operands and a start mid-run (R7).
  task automatic runSmall(input logic [WS-1:0] a, input logic [WS-1:0] b,
                          input logic [WS-1:0] n, input bit disturb);
    int cyc;
    logic [127:0] exp;
    exp = refMont(128'(a), 128'(b), 128'(n), WS);
    @(negedge clk);
    sA = a; sB = b; sN = n; sStart = 1'b1;
    @(negedge clk);
    sStart = 1'b0;
    cyc = 1;
    while (!sDone && cyc < 100) begin
      if (disturb && cyc == 4) begin
        sA = ~a; sB = 8'h01; sN = 8'hfd; sStart = 1'b1;
      end else sStart = 1'b0;
      @(negedge clk);
      cyc++;
    end
    sStart = 1'b0;
    check(sRes == exp[WS-1:0], disturb ? "R7 result" : "R1 result",
          128'(sRes), exp);
    check(cyc == WS + 4, disturb ? "R7 latency" : "R4 latency",
          128'(cyc), 128'(WS + 4));
    if (n > 1) check(sRes < n, "R2 range", 128'(sRes), 128'(n));
    @(negedge clk);
    check(sDone == 1'b0, "R5 done width", 128'(sDone), 128'd0);
  endtask

  task automatic runWide(input logic [WL-1:0] a, input logic [WL-1:0] b,
                         input logic [WL-1:0] n);
    int cyc;
    logic [127:0] exp;
    exp = refMont(128'(a), 128'(b), 128'(n), WL);
    @(negedge clk);
    lA = a; lB = b; lN = n; lStart = 1'b1;
    @(negedge clk);
    lStart = 1'b0;
    cyc = 1;
    while (!lDone && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    check(lRes == exp[WL-1:0], "R1 wide result", 128'(lRes), exp);
    check(lRes < n, "R2 wide range", 128'(lRes), 128'(n));
    check(cyc == WL + 4, "R4 wide latency", 128'(cyc), 128'(WL + 4));
    @(negedge clk);
    check(lDone == 1'b0, "R5 wide done width", 128'(lDone), 128'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [WS-1:0] held;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(sDone == 1'b0, "R8 done in reset", 128'(sDone), 128'd0);
    check(sRes == '0, "R8 result in reset", 128'(sRes), 128'd0);
    check(lRes == '0, "R8 wide result in reset", 128'(lRes), 128'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R4 R5: sweep of every odd modulus
    for (int n = 1; n < 256; n += 2) begin
      logic [WS-1:0] bv [6];
      logic [WS-1:0] av [8];
      bv[0] = 0; bv[1] = (n > 1) ? 1 : 0; bv[2] = WS'(n - 1);
      bv[3] = WS'(n / 2); bv[4] = WS'((n * 3) / 7); bv[5] = WS'((n * 5) / 9);
      av[0] = 0; av[1] = 1; av[2] = 8'hff; av[3] = 8'h80;
      av[4] = 8'h55; av[5] = 8'haa; av[6] = WS'(n - 1); av[7] = WS'(n * 7 + 3);
      for (int bi = 0; bi < 6; bi++)
        for (int ai = 0; ai < 8; ai++)
          runSmall(av[ai], bv[bi], WS'(n), 1'b0);
    end

    // R7: start and operand changes during a run are ignored
    runSmall(8'hc3, 8'h5a, 8'hbb, 1'b1);
    runSmall(8'h01, 8'hee, 8'hef, 1'b1);

    // R6: result held while inputs change without start
    held = sRes;
    @(negedge clk);
    sA = 8'h33; sB = 8'h02; sN = 8'h07;
    repeat (6) @(negedge clk);
    check(sRes == held, "R6 result hold", 128'(sRes), 128'(held));

    // R1 R3: wide operands near the top of the range
    runWide('1, 64'hffff_ffff_ffff_fffe, '1);
    runWide(64'h0123_4567_89ab_cdef, 64'h0fed_cba9_8765_4321,
            64'hc000_0000_0000_0001);
    runWide(64'h8000_0000_0000_0000, 64'h1, 64'hffff_ffff_ffff_ffc5);
    runWide(64'h0, 64'h1234, 64'h1_0000_0001);
    runWide(64'hdead_beef_cafe_f00d, 64'h7fff_ffff_ffff_ffff,
            64'h8000_0000_0000_0001);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule